// File: doc/BRIEF.md
# Auto-Reload Overflow Timer

This block is a 32-bit up-counting timer that sits on a simple single-cycle register bus. Software loads a starting value, sets the run bit, and the counter advances by one on every cycle in which the external tick enable is high. When the count passes all-ones, the block raises an overflow flag. It then either restarts from the programmed load value (auto-reload) or wraps to zero and stops itself (one-shot).

A level interrupt is raised while the overflow flag and its enable bit are both set. Software clears the flag by writing a one to it. The register addresses come in one of two layouts, chosen by a parameter. That lets the same block sit behind decoders built for either address arrangement. Match and capture enables are stored and read back, but no match or capture logic exists behind them.

Top module: `ovf_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: With `LAYOUT`=0 the status, enable, control, counter and load registers sit at byte offsets 0x28, 0x2C, 0x38, 0x3C, 0x40. With `LAYOUT`=1 they sit at 0x18, 0x1C, 0x24, 0x28, 0x2C.
- R3: The counter rises by exactly one on each cycle in which control bit 0 (run) is set and `tick_en` is high. Otherwise it holds.
- R4: With control bit 1 (auto-reload) set, a tick at count 0xFFFFFFFF loads the counter from the load register, sets status bit 1 and leaves run set. The period is therefore 0xFFFFFFFF − load + 1 ticks.
- R5: With auto-reload clear, a tick at count 0xFFFFFFFF sets the counter to zero, sets status bit 1 and clears run, so counting stops.
- R6: Writing status with bit 1 at one clears the overflow flag. Writing bit 1 at zero leaves it unchanged. An overflow in the same cycle as a clear leaves the flag set.
- R7: `irq` is high while status bit 1 and enable bit 1 are both set. It is low in the cycle after the flag is cleared.
- R8: A bus write to the counter wins over an increment or reload in the same cycle. The counter takes the written value and no overflow is flagged.
- R9: The enable register keeps bits 2:0 (bit 0 match, bit 1 overflow, bit 2 capture), and control keeps bits 1:0. All other bits of these registers, and status bits other than bit 1, read as zero.
- R10: Reads of unmapped offsets return zero, and writes to them change no register.
- R11: `bus_rvalid` is high in the cycle after `bus_rd`. `bus_rdata` then carries the register value as it stood in the read cycle, including the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count enable, one tick per high cycle |
| bus_addr | input | AW | Byte offset of the access |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after bus_rd |
| irq | output | 1 | Level interrupt from enabled status |

## Verification
The bench loads counts just below all-ones, so random ticks keep crossing the wrap in both reload modes. A design that reloaded from zero, kept running in one-shot mode, or skipped the flag would show a wrong count or a stuck `irq`. It also hits the collisions on purpose: a counter write landing on the wrap tick, and a flag clear landing on a new overflow. A design with the wrong priority would show a stray reloaded value or a lost interrupt. Writes to unmapped offsets and the second address layout confirm that decoding neither aliases nor misses a register.

// File: rtl/ovf_timer.sv
module ovf_timer #(
  parameter int LAYOUT = 0,
  parameter int AW = 8,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_en,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_rvalid,
  output logic          irq
);

  localparam logic [AW-1:0] OFF_ST  = AW'(LAYOUT == 0 ? 40 : 24);
  localparam logic [AW-1:0] OFF_EN  = AW'(LAYOUT == 0 ? 44 : 28);
  localparam logic [AW-1:0] OFF_CTL = AW'(LAYOUT == 0 ? 56 : 36);
  localparam logic [AW-1:0] OFF_CNT = AW'(LAYOUT == 0 ? 60 : 40);
  localparam logic [AW-1:0] OFF_LD  = AW'(LAYOUT == 0 ? 64 : 44);
  localparam logic [DW-1:0] CMAX    = '1;

  logic [2:0]    st_q, en_q;
  logic [1:0]    ctl_q;
  logic [DW-1:0] cnt_q, ld_q, rmux;

  wire wr_st  = bus_wr && bus_addr == OFF_ST;
  wire wr_en  = bus_wr && bus_addr == OFF_EN;
  wire wr_ctl = bus_wr && bus_addr == OFF_CTL;
  wire wr_cnt = bus_wr && bus_addr == OFF_CNT;
  wire wr_ld  = bus_wr && bus_addr == OFF_LD;
  wire hit    = wr_st | wr_en | wr_ctl | wr_cnt | wr_ld;
  wire step   = ctl_q[0] && tick_en;
  wire wrap   = step && cnt_q == CMAX && !wr_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (wr_cnt) cnt_q <= bus_wdata;
    else if (wrap)   cnt_q <= ctl_q[1] ? ld_q : '0;
    else if (step)   cnt_q <= cnt_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= '0;
      en_q  <= '0;
      ctl_q <= '0;
      ld_q  <= '0;
    end else begin
      st_q <= {1'b0, wrap | (st_q[1] & ~(wr_st & bus_wdata[1])), 1'b0};
      if (wr_en) en_q <= bus_wdata[2:0];
      if (wr_ld) ld_q <= bus_wdata;
      if (wr_ctl) ctl_q <= bus_wdata[1:0];
      else if (wrap && !ctl_q[1]) ctl_q[0] <= 1'b0;
    end
  end

  always_comb begin
    rmux = '0;
    case (bus_addr)
      OFF_ST:  rmux = DW'(st_q);
      OFF_EN:  rmux = DW'(en_q);
      OFF_CTL: rmux = DW'(ctl_q);
      OFF_CNT: rmux = cnt_q;
      OFF_LD:  rmux = ld_q;
      default: rmux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
    end else begin
      bus_rvalid <= bus_rd;
      bus_rdata  <= bus_rd ? rmux : '0;
    end
  end

  assign irq = |(st_q & en_q);

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!step && !wr_cnt) |=> $stable(cnt_q));
  assert_inc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_cnt && cnt_q != CMAX) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_reload_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_cnt && cnt_q == CMAX && ctl_q[1]) |=> (cnt_q == $past(ld_q) && st_q[1]));
  assert_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !wr_cnt && !wr_ctl && cnt_q == CMAX && !ctl_q[1]) |=> (cnt_q == '0 && !ctl_q[0] && st_q[1]));
  assert_keep_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q[1] && !(wr_st && bus_wdata[1])) |=> st_q[1]);
  assert_irq_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_st && bus_wdata[1] && !wrap) |=> !irq);
  assert_wr_prio_R8: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cnt |=> cnt_q == $past(bus_wdata));
  assert_unmapped_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !hit && !step) |=> ($stable(cnt_q) && $stable(ld_q) && $stable(en_q) && $stable(ctl_q)));
  assert_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> bus_rvalid);
  assert_no_rvalid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |=> !bus_rvalid);

endmodule

// File: tb/ovf_timer_test.sv
module ovf_timer_test;
  logic clk = 0;
  logic rst_n = 0;
  logic tick_en = 0, bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic bus_rvalid, irq;

  logic b_wr = 0, b_rd = 0;
  logic [7:0] b_addr = '0;
  logic [31:0] b_wdata = '0;
  logic [31:0] b_rdata;
  logic b_rvalid, b_irq;

  int total = 0, bad = 0;

  localparam logic [7:0] ST = 8'h28, EN = 8'h2C, CTL = 8'h38, CNT = 8'h3C, LD = 8'h40;

  logic [31:0] m_cnt, m_ld;
  logic [2:0]  m_st, m_en;
  logic [1:0]  m_ctl;

  always #2 clk = ~clk;

  ovf_timer #(.LAYOUT(0)) uut (.clk(clk), .rst_n(rst_n), .tick_en(tick_en), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_rvalid(bus_rvalid), .irq(irq));

  ovf_timer #(.LAYOUT(1)) uut_b (.clk(clk), .rst_n(rst_n), .tick_en(1'b0), .bus_addr(b_addr),
    .bus_wr(b_wr), .bus_rd(b_rd), .bus_wdata(b_wdata), .bus_rdata(b_rdata),
    .bus_rvalid(b_rvalid), .irq(b_irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mread(input logic [7:0] a);
    case (a)
      ST:  return {29'd0, m_st};
      EN:  return {29'd0, m_en};
      CTL: return {30'd0, m_ctl};
      CNT: return m_cnt;
      LD:  return m_ld;
      default: return 32'd0;
    endcase
  endfunction

  task automatic mstep(input logic w, input logic [7:0] a, input logic [31:0] d, input logic t);
    logic inc, cw, ovf;
    logic [31:0] old_ld;
    inc = t && m_ctl[0];
    cw = w && a == CNT;
    ovf = 0;
    old_ld = m_ld;
    if (cw) m_cnt = d;
    else if (inc) begin
      if (m_cnt == 32'hFFFF_FFFF) begin
        ovf = 1;
        m_cnt = m_ctl[1] ? old_ld : 32'd0;
      end else m_cnt = m_cnt + 1;
    end
    if (w && a == ST && d[1]) m_st[1] = 1'b0;
    if (ovf) m_st[1] = 1'b1;
    if (w && a == EN) m_en = d[2:0];
    if (w && a == LD) m_ld = d;
    if (w && a == CTL) m_ctl = d[1:0];
    else if (ovf && !m_ctl[1]) m_ctl[0] = 1'b0;
  endtask

  task automatic cyc(input logic w, input logic r, input logic [7:0] a, input logic [31:0] d,
                     input logic t, input string tag);
    logic [31:0] exp_rd;
    @(negedge clk);
    bus_wr = w; bus_rd = r; bus_addr = a; bus_wdata = d; tick_en = t;
    exp_rd = mread(a);
    mstep(w, a, d, t);
    @(negedge clk);
    bus_wr = 0; bus_rd = 0; tick_en = 0;
    if (r) begin
      chk({tag, " rvalid R11"}, {31'd0, bus_rvalid}, 32'd1);
      chk({tag, " rdata"}, bus_rdata, exp_rd);
    end
    chk({tag, " irq R7"}, {31'd0, irq}, {31'd0, |(m_st & m_en)});
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input string tag);
    cyc(1, 0, a, d, 0, tag);
  endtask
  task automatic rd(input logic [7:0] a, input string tag);
    cyc(0, 1, a, 0, 0, tag);
  endtask

  task automatic finish_run;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    m_cnt = 0; m_ld = 0; m_st = 0; m_en = 0; m_ctl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    foreach (uut.OFF_ST[i]) ;
    rd(ST, "R1"); rd(EN, "R1"); rd(CTL, "R1"); rd(CNT, "R1"); rd(LD, "R1");
    chk("R1 irq", {31'd0, irq}, 32'd0);

    wr(EN, 32'hFFFF_FFFF, "R9");
    rd(EN, "R9");
    chk("R9 enable bits", bus_rdata, 32'd7);
    wr(CTL, 32'hFFFF_FFFC, "R9");
    rd(CTL, "R9");
    chk("R9 control bits", bus_rdata, 32'd0);

    wr(CNT, 32'd100, "R3");
    wr(CTL, 32'd1, "R3");
    cyc(0, 0, 0, 0, 1, "R3");
    cyc(0, 0, 0, 0, 0, "R3");
    cyc(0, 0, 0, 0, 1, "R3");
    rd(CNT, "R3");
    chk("R3 two ticks", bus_rdata, 32'd102);

    wr(LD, 32'hFFFF_FFFC, "R4");
    wr(CNT, 32'hFFFF_FFFE, "R4");
    wr(CTL, 32'd3, "R4");
    cyc(0, 0, 0, 0, 1, "R4");
    cyc(0, 1, CNT, 0, 1, "R4");
    chk("R4 pre-wrap live count", bus_rdata, 32'hFFFF_FFFF);
    rd(CNT, "R4");
    chk("R4 reload value", bus_rdata, 32'hFFFF_FFFC);
    rd(ST, "R4");
    chk("R4 flag", bus_rdata, 32'd2);
    chk("R7 irq high", {31'd0, irq}, 32'd1);
    rd(CTL, "R4");
    chk("R4 run kept", bus_rdata, 32'd3);
    for (int k = 0; k < 4; k++) cyc(0, 0, 0, 0, 1, "R4");
    rd(CNT, "R4");
    chk("R4 period of four", bus_rdata, 32'hFFFF_FFFC);

    wr(ST, 32'd0, "R6");
    rd(ST, "R6");
    chk("R6 zero write keeps", bus_rdata, 32'd2);
    wr(ST, 32'd2, "R6");
    chk("R7 irq drop", {31'd0, irq}, 32'd0);
    rd(ST, "R6");
    chk("R6 cleared", bus_rdata, 32'd0);

    wr(CTL, 32'd1, "R5");
    wr(CNT, 32'hFFFF_FFFF, "R5");
    cyc(0, 0, 0, 0, 1, "R5");
    rd(CNT, "R5");
    chk("R5 wrap to zero", bus_rdata, 32'd0);
    rd(CTL, "R5");
    chk("R5 run cleared", bus_rdata, 32'd0);
    cyc(0, 0, 0, 0, 1, "R5");
    rd(CNT, "R5");
    chk("R5 stopped", bus_rdata, 32'd0);
    wr(ST, 32'd2, "R5");

    wr(CTL, 32'd3, "R8");
    wr(CNT, 32'hFFFF_FFFF, "R8");
    cyc(1, 0, CNT, 32'd5, 1, "R8");
    rd(CNT, "R8");
    chk("R8 write wins", bus_rdata, 32'd5);
    rd(ST, "R8");
    chk("R8 no flag", bus_rdata, 32'd0);

    wr(CNT, 32'hFFFF_FFFF, "R6");
    cyc(1, 0, ST, 32'd2, 1, "R6");
    rd(ST, "R6");
    chk("R6 overflow beats clear", bus_rdata, 32'd2);

    wr(CTL, 32'd0, "R10");
    wr(8'h30, 32'hDEAD_BEEF, "R10");
    wr(8'h18, 32'h1234_5678, "R10");
    rd(8'h30, "R10");
    chk("R10 unmapped read", bus_rdata, 32'd0);
    rd(CNT, "R10"); rd(LD, "R10"); rd(EN, "R10"); rd(CTL, "R10");

    @(negedge clk);
    b_wr = 1; b_addr = 8'h2C; b_wdata = 32'h0000_1234;
    @(negedge clk);
    b_wr = 1; b_addr = 8'h1C; b_wdata = 32'h0000_0002;
    @(negedge clk);
    b_wr = 0; b_rd = 1; b_addr = 8'h2C;
    @(negedge clk);
    chk("R2 layout B load", b_rdata, 32'h0000_1234);
    b_addr = 8'h1C;
    @(negedge clk);
    chk("R2 layout B enable", b_rdata, 32'd2);
    b_addr = 8'h40;
    @(negedge clk);
    chk("R2 layout B no reg at 0x40", b_rdata, 32'd0);
    b_rd = 0;

    for (int n = 0; n < 4000; n++) begin
      int sel;
      logic [7:0] a;
      logic [31:0] d;
      sel = int'($urandom_range(0, 9));
      a = (sel[0]) ? CNT : LD;
      case ($urandom_range(0, 6))
        0: a = ST; 1: a = EN; 2: a = CTL; 3: a = CNT; 4: a = LD; 5: a = 8'h34; default: ;
      endcase
      d = $urandom();
      if (a == CNT || a == LD) d = 32'hFFFF_FFF0 | (d & 32'hF);
      if (a == CTL && $urandom_range(0, 3) != 0) d[0] = 1'b1;
      if (sel < 3) cyc(1, 0, a, d, 1'($urandom_range(0, 1)), "R6 random write");
      else if (sel < 6) cyc(0, 1, a, 0, 1'($urandom_range(0, 1)), "R11 random read");
      else cyc(0, 0, 0, 0, 1'($urandom_range(0, 1)), "R3 random tick");
    end

    finish_run();
  end
endmodule